// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers interrupt request lines, arranged in groups of 32, and tells a processor which one to serve. Each line has a pending flag, an enable bit and a 4-bit priority, where 0 is the most urgent level and 15 the least urgent. Of all sources that are pending, enabled and not blocked, the controller picks one. It raises `irq_o` and shows that source's index in a vector register. A 16-bit level-enable register can block whole priority levels. One source, the last index by default, has no hardware line. It becomes pending only when software writes a trigger register.

Handler flow: software reads the vector register with `bus_rd_i` high. This is the take. It returns the winner and blocks that winner's priority level from the next cycle. The handler then clears the source's pending bit by writing a one to it, so a new event can be latched while the handler runs. Finally it writes any value to the vector register. This is the acknowledge. It lifts the automatic block and arbitration resumes.

The register bus is a plain synchronous port with one access per cycle. There is no stream traffic, so there is no valid/ready handshake and no back-pressure. Read data is combinational from the address and the current state.

Register map (byte addresses):
- `0x000`: level enable. Bit p enables priority p. Reset value is 0xFFFF.
- `0x004`: vector. A read returns the winner index, or 0x3FF when nothing is eligible. A write is the acknowledge.
- `0x008`: software trigger. Any write sets the software source pending. Reads return 0.
- Group g has a block of registers at `0x100 + 0x20*g`:
  - `+0x00`: pending. Reads the pending flags. Writing 1 to a bit clears it.
  - `+0x04`: enable. Bit b enables source 32g+b.
  - `+0x08`, `+0x0C`, `+0x10`, `+0x14`: priority words w = 0..3. Bits [4k+3:4k] of word w hold the priority of source 32g+8w+k.

Top module: `vic_top`

## Requirements
- R1: After reset, `irq_o` is low, the vector register reads 0x3FF, and the level-enable register reads 0xFFFF. All enable bits, priorities and pending flags are zero.
- R2: A rising edge on a hardware line sets that source's pending flag, which is bit (n mod 32) of the pending register of group n/32. A line held high does not set the flag again after it has been cleared.
- R3: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. If a clear and a new rising edge hit the same bit in the same cycle, the edge wins.
- R4: The winner is the eligible source with the smallest priority value. Ties go to the lowest index. The vector register reads the winner's index, and `irq_o` is high exactly when a winner exists.
- R5: A source is eligible only if it is pending, its enable bit is 1, its level-enable bit is 1 and its level is not auto-blocked. A level-enable write takes effect on `irq_o` in the cycle after the write.
- R6: A write to `0x008` sets the software source pending in the next cycle. Its hardware input line is ignored.
- R7: A take, meaning a vector read with `bus_rd_i` high while a winner exists, blocks every source at the winner's level from the next cycle. The software source is included.
- R8: A write to the vector register releases the numerically smallest blocked level, and arbitration resumes in the next cycle. A take in the same cycle is applied after the release.
- R9: Priority words read back as written: bits [4k+3:4k] of word w belong to source 32g+8w+k.
- R10: A software interrupt posted while its level is disabled, or while it is auto-blocked, is not delivered. It is delivered once that block is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src_i | input | GROUPS*32 | Hardware request lines (bit SWI_SRC is ignored) |
| bus_addr_i | input | 12 | Register byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe (a vector read with this high is a take) |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The hardest state to reach is several priority levels blocked at once while a software interrupt waits behind one of them. Reaching it needs a chain of takes and acknowledges that leaves exactly the right level blocked. The stimulus builds this directly. It takes level 3, then level 7, acknowledges one at a time, and then posts the software source both into a disabled level and into an auto-blocked level. A long random phase follows, compared against a behavioural model on every cycle. In that phase, takes, acknowledges, clears and line edges often land in the same cycle.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 32;
  localparam int PRIO_W    = 4;
  localparam int NUM_LVL   = 1 << PRIO_W;
  localparam int GRP_SIZE  = 32;
  localparam int VEC_W     = 10;
  localparam int SLOTS     = DATA_W / PRIO_W;
  localparam int PRI_WORDS = GRP_SIZE / SLOTS;
  localparam int OFF_W     = $clog2(GRP_SIZE);

  localparam logic [ADDR_W-1:0] LVL_ADDR = 12'h000;
  localparam logic [ADDR_W-1:0] VEC_ADDR = 12'h004;
  localparam logic [ADDR_W-1:0] SWI_ADDR = 12'h008;
  localparam logic [ADDR_W-1:0] GRP_BASE = 12'h100;

  localparam logic [OFF_W-1:0] PEND_OFF = 5'h00;
  localparam logic [OFF_W-1:0] EN_OFF   = 5'h04;
  localparam logic [OFF_W-1:0] PRI_OFF  = 5'h08;

  localparam logic [VEC_W-1:0] NO_VEC = '1;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [NUM_LVL-1:0] lvl_vec_t;

  // Isolate the least significant set bit.
  function automatic lvl_vec_t lowest_one(input lvl_vec_t v);
    return v & (~v + lvl_vec_t'(1));
  endfunction
endpackage

// File: rtl/vic_pending.sv
module vic_pending #(
  parameter int NSRC = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] line_i,
  input  logic [NSRC-1:0] soft_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] line_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic rise;
    assign rise = line_i[i] & ~line_q[i];
    always_ff @(posedge clk) begin
      if (rst) begin
        line_q[i] <= 1'b0;
        pend_o[i] <= 1'b0;
      end else begin
        line_q[i] <= line_i[i];
        // set sources win over a clear in the same cycle
        pend_o[i] <= (pend_o[i] & ~clr_i[i]) | rise | soft_i[i];
      end
    end
  end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
  import vic_pkg::*;
#(
  parameter int GROUPS = 2
) (
  input  logic [GROUPS*GRP_SIZE-1:0] elig_i,
  input  prio_t [GROUPS*GRP_SIZE-1:0] prio_i,
  output logic                       valid_o,
  output logic [VEC_W-1:0]           idx_o,
  output prio_t                      prio_o
);
  logic [GROUPS-1:0]  g_valid;
  logic [VEC_W-1:0]   g_idx  [GROUPS];
  prio_t              g_prio [GROUPS];

  // first stage: one local winner per group
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    always_comb begin
      g_valid[g] = 1'b0;
      g_idx[g]   = '0;
      g_prio[g]  = '1;
      for (int b = 0; b < GRP_SIZE; b++) begin
        if (elig_i[g*GRP_SIZE+b] &&
            (!g_valid[g] || prio_i[g*GRP_SIZE+b] < g_prio[g])) begin
          g_valid[g] = 1'b1;
          g_idx[g]   = VEC_W'(g*GRP_SIZE + b);
          g_prio[g]  = prio_i[g*GRP_SIZE+b];
        end
      end
    end
  end

  // second stage: strict compare keeps the lower group on ties
  always_comb begin
    valid_o = 1'b0;
    idx_o   = NO_VEC;
    prio_o  = '1;
    for (int g = 0; g < GROUPS; g++) begin
      if (g_valid[g] && (!valid_o || g_prio[g] < prio_o)) begin
        valid_o = 1'b1;
        idx_o   = g_idx[g];
        prio_o  = g_prio[g];
      end
    end
  end
endmodule

// File: rtl/vic_levels.sv
module vic_levels
  import vic_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     lvl_wr_i,
  input  lvl_vec_t lvl_data_i,
  input  logic     take_i,
  input  prio_t    take_lvl_i,
  input  logic     ack_i,
  output lvl_vec_t lvl_en_o,
  output lvl_vec_t act_o
);
  lvl_vec_t released;
  lvl_vec_t taken;

  assign released = ack_i ? (act_o & ~lowest_one(act_o)) : act_o;
  assign taken    = take_i ? (lvl_vec_t'(1) << take_lvl_i) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_en_o <= '1;
      act_o    <= '0;
    end else begin
      if (lvl_wr_i) lvl_en_o <= lvl_data_i;
      act_o <= released | taken;
    end
  end
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int GROUPS  = 2,
  parameter int SWI_SRC = GROUPS*GRP_SIZE - 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [GROUPS*GRP_SIZE-1:0] irq_src_i,
  input  logic [ADDR_W-1:0]          bus_addr_i,
  input  logic [DATA_W-1:0]          bus_wdata_i,
  input  logic                       bus_wr_i,
  input  logic                       bus_rd_i,
  output logic [DATA_W-1:0]          bus_rdata_o,
  output logic                       irq_o
);
  localparam int NSRC = GROUPS * GRP_SIZE;
  localparam int GW   = ADDR_W - OFF_W;
  localparam logic [NSRC-1:0] SWI_MASK = NSRC'(1) << SWI_SRC;

  logic [GROUPS-1:0] grp_hit;
  logic [OFF_W-1:0]  reg_off;
  logic              wr_lvl, wr_vec, rd_vec, wr_swi;
  logic [NSRC-1:0]   en_q, pend, clr, elig;
  prio_t [NSRC-1:0]  prio_q;
  lvl_vec_t          lvl_en, act;
  logic              win_valid;
  logic [VEC_W-1:0]  win_idx;
  prio_t             win_prio;
  logic              pend_swi;

  assign reg_off = bus_addr_i[OFF_W-1:0];
  assign wr_lvl  = bus_wr_i && bus_addr_i == LVL_ADDR;
  assign wr_vec  = bus_wr_i && bus_addr_i == VEC_ADDR;
  assign rd_vec  = bus_rd_i && bus_addr_i == VEC_ADDR;
  assign wr_swi  = bus_wr_i && bus_addr_i == SWI_ADDR;

  for (genvar g = 0; g < GROUPS; g++) begin : g_dec
    localparam int unsigned GSEL = int'(GRP_BASE >> OFF_W) + g;
    assign grp_hit[g] = bus_addr_i[ADDR_W-1:OFF_W] == GW'(GSEL);
    assign clr[g*GRP_SIZE +: GRP_SIZE] =
      (bus_wr_i && grp_hit[g] && reg_off == PEND_OFF) ? bus_wdata_i : '0;
  end

  // enable and priority storage
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      prio_q <= '0;
    end else if (bus_wr_i) begin
      for (int g = 0; g < GROUPS; g++) begin
        if (grp_hit[g] && reg_off == EN_OFF)
          en_q[g*GRP_SIZE +: GRP_SIZE] <= bus_wdata_i;
        for (int w = 0; w < PRI_WORDS; w++) begin
          if (grp_hit[g] && reg_off == PRI_OFF + OFF_W'(4*w))
            for (int k = 0; k < SLOTS; k++)
              prio_q[g*GRP_SIZE + w*SLOTS + k] <= bus_wdata_i[k*PRIO_W +: PRIO_W];
        end
      end
    end
  end

  vic_pending #(.NSRC(NSRC)) u_pend (
    .clk    (clk),
    .rst    (rst),
    .line_i (irq_src_i & ~SWI_MASK),
    .soft_i (wr_swi ? SWI_MASK : '0),
    .clr_i  (clr),
    .pend_o (pend)
  );

  assign pend_swi = pend[SWI_SRC];

  always_comb begin
    for (int i = 0; i < NSRC; i++)
      elig[i] = pend[i] & en_q[i] & lvl_en[prio_q[i]] & ~act[prio_q[i]];
  end

  vic_arbiter #(.GROUPS(GROUPS)) u_arb (
    .elig_i  (elig),
    .prio_i  (prio_q),
    .valid_o (win_valid),
    .idx_o   (win_idx),
    .prio_o  (win_prio)
  );

  vic_levels u_lvl (
    .clk        (clk),
    .rst        (rst),
    .lvl_wr_i   (wr_lvl),
    .lvl_data_i (bus_wdata_i[NUM_LVL-1:0]),
    .take_i     (rd_vec && win_valid),
    .take_lvl_i (win_prio),
    .ack_i      (wr_vec),
    .lvl_en_o   (lvl_en),
    .act_o      (act)
  );

  assign irq_o = win_valid;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == LVL_ADDR) begin
      bus_rdata_o = DATA_W'(lvl_en);
    end else if (bus_addr_i == VEC_ADDR) begin
      bus_rdata_o = DATA_W'(win_idx);
    end else begin
      for (int g = 0; g < GROUPS; g++) begin
        if (grp_hit[g]) begin
          if (reg_off == PEND_OFF) bus_rdata_o = pend[g*GRP_SIZE +: GRP_SIZE];
          if (reg_off == EN_OFF)   bus_rdata_o = en_q[g*GRP_SIZE +: GRP_SIZE];
          for (int w = 0; w < PRI_WORDS; w++) begin
            if (reg_off == PRI_OFF + OFF_W'(4*w))
              for (int k = 0; k < SLOTS; k++)
                bus_rdata_o[k*PRIO_W +: PRIO_W] = prio_q[g*GRP_SIZE + w*SLOTS + k];
          end
        end
      end
    end
  end
endmodule

// File: rtl/vic_chk.sv
module vic_chk
  import vic_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              irq_o,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [VEC_W-1:0]  vec_rd,
  input prio_t             win_prio,
  input lvl_vec_t          lvl_en,
  input lvl_vec_t          act,
  input logic              pend_swi
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!irq_o && act == '0));

  // R4
  vec_irq_agree_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr_i == VEC_ADDR) |-> (irq_o == (vec_rd != NO_VEC)));

  // R5
  lvl_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> lvl_en[win_prio]);

  // R7
  same_lvl_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> !act[win_prio]);

  // R7
  take_masks_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_i && bus_addr_i == VEC_ADDR && irq_o && !bus_wr_i) |=> act[$past(win_prio)]);

  // R8
  ack_release_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_i && bus_addr_i == VEC_ADDR && !bus_rd_i && act != '0)
      |=> ($countones(act) == $countones($past(act)) - 1));

  // R6
  swi_post_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_i && bus_addr_i == SWI_ADDR) |=> pend_swi);
endmodule

bind vic_top vic_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .irq_o      (irq_o),
  .bus_addr_i (bus_addr_i),
  .bus_wr_i   (bus_wr_i),
  .bus_rd_i   (bus_rd_i),
  .vec_rd     (bus_rdata_o[9:0]),
  .win_prio   (win_prio),
  .lvl_en     (lvl_en),
  .act        (act),
  .pend_swi   (pend_swi)
);

// File: tb/test_vic_top.sv
`timescale 1ns/1ps
module test_vic_top;
  localparam int NG   = 2;
  localparam int NSRC = NG * 32;
  localparam int SWI  = NSRC - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [NSRC-1:0] src_v = '0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string phase = "R1";

  // reference model state
  logic [NSRC-1:0] m_pend, m_en, m_srcq;
  int              m_pri [NSRC];
  logic [15:0]     m_lvl, m_act;

  always #2.5 clk = ~clk;

  vic_top i_vic_top (
    .clk(clk), .rst(rst), .irq_src_i(src_v), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  function automatic void m_win(output int w, output int pr);
    w = -1; pr = 99;
    for (int i = 0; i < NSRC; i++)
      if (m_pend[i] && m_en[i] && m_lvl[m_pri[i]] && !m_act[m_pri[i]] && m_pri[i] < pr) begin
        w = i; pr = m_pri[i];
      end
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    logic [31:0] r = '0;
    int w, pr, g, o, base;
    if (a == 12'h000) r = {16'h0, m_lvl};
    else if (a == 12'h004) begin
      m_win(w, pr);
      r = (w < 0) ? 32'h3FF : 32'(w);
    end else if (a >= 12'h100 && a < 12'h100 + NG*32) begin
      g = (int'(a) - 256) / 32;
      o = (int'(a) - 256) % 32;
      if (o == 0) r = m_pend[g*32 +: 32];
      if (o == 4) r = m_en[g*32 +: 32];
      if (o == 8 || o == 12 || o == 16 || o == 20) begin
        base = g*32 + (o - 8) / 4 * 8;
        for (int k = 0; k < 8; k++) r[k*4 +: 4] = 4'(m_pri[base + k]);
      end
    end
    return r;
  endfunction

  function automatic void m_tick(input logic [11:0] a, input logic [31:0] wd,
                                 input logic wr, input logic rd, input logic [NSRC-1:0] s);
    int w, pr, g, o, base;
    logic [NSRC-1:0] np;
    logic [15:0] na;
    m_win(w, pr);
    np = m_pend;
    na = m_act;
    if (wr && a == 12'h004) begin
      for (int l = 0; l < 16; l++) if (na[l]) begin na[l] = 1'b0; break; end
    end
    if (rd && a == 12'h004 && w >= 0) na[pr] = 1'b1;
    if (wr && a == 12'h000) m_lvl = wd[15:0];
    if (wr && a >= 12'h100 && a < 12'h100 + NG*32) begin
      g = (int'(a) - 256) / 32;
      o = (int'(a) - 256) % 32;
      if (o == 0) np[g*32 +: 32] = np[g*32 +: 32] & ~wd;
      if (o == 4) m_en[g*32 +: 32] = wd;
      if (o == 8 || o == 12 || o == 16 || o == 20) begin
        base = g*32 + (o - 8) / 4 * 8;
        for (int k = 0; k < 8; k++) m_pri[base + k] = int'(wd[k*4 +: 4]);
      end
    end
    for (int i = 0; i < NSRC; i++)
      if (i != SWI && s[i] && !m_srcq[i]) np[i] = 1'b1;
    if (wr && a == 12'h008) np[SWI] = 1'b1;
    m_srcq = s;
    m_pend = np;
    m_act  = na;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  // one bus cycle: drive, compare against the model, clock, update the model
  task automatic step(input logic [11:0] a, input logic [31:0] wd, input logic wr, input logic rd);
    logic [NSRC-1:0] s;
    bus_addr = a; bus_wdata = wd; bus_wr = wr; bus_rd = rd;
    s = src_v;
    #1;
    chk(phase, {31'b0, irq}, (m_read(12'h004) != 32'h3FF) ? 32'd1 : 32'd0);
    chk(phase, rdata, m_read(a));
    @(posedge clk);
    m_tick(a, wd, wr, rd, s);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic expect_rd(input logic [11:0] a, input logic [31:0] exp_v, input string tag);
    bus_addr = a; bus_wr = 1'b0; bus_rd = 1'b0;
    #1;
    chk(tag, rdata, exp_v);
    step(a, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    step(a, d, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_pend = '0; m_en = '0; m_srcq = '0; m_lvl = 16'hFFFF; m_act = '0;
    for (int i = 0; i < NSRC; i++) m_pri[i] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    phase = "R1";
    #1 chk("R1", {31'b0, irq}, 32'd0);
    expect_rd(12'h000, 32'h0000FFFF, "R1");
    expect_rd(12'h004, 32'h000003FF, "R1");
    expect_rd(12'h100, 32'h0, "R1");
    expect_rd(12'h108, 32'h0, "R1");

    // R9 priority layout
    phase = "R9";
    wr(12'h108, 32'h0030_0000);      // source 5 -> 3
    wr(12'h10C, 32'h0000_0700);      // source 10 -> 7
    wr(12'h12C, 32'h0000_0003);      // source 40 -> 3
    wr(12'h134, 32'hF000_0000);      // source 63 -> 15
    expect_rd(12'h108, 32'h0030_0000, "R9");
    expect_rd(12'h12C, 32'h0000_0003, "R9");
    expect_rd(12'h134, 32'hF000_0000, "R9");
    wr(12'h104, 32'hFFFF_FFFF);
    wr(12'h124, 32'hFFFF_FFFF);

    // R2 edge sets pending
    phase = "R2";
    src_v[10] = 1'b1;
    step(12'h000, 0, 0, 0);
    expect_rd(12'h100, 32'h0000_0400, "R2");
    expect_rd(12'h004, 32'd10, "R2");

    // R4 priority and tie order
    phase = "R4";
    src_v[40] = 1'b1; src_v[5] = 1'b1;
    step(12'h000, 0, 0, 0);
    expect_rd(12'h004, 32'd5, "R4");
    expect_rd(12'h120, 32'h0000_0100, "R2");

    // R3 write-one-to-clear
    phase = "R3";
    wr(12'h100, 32'h0000_0020);
    expect_rd(12'h004, 32'd40, "R3");
    expect_rd(12'h100, 32'h0000_0400, "R2");   // line 5 held high: no re-set
    wr(12'h100, 32'h0);
    expect_rd(12'h100, 32'h0000_0400, "R3");
    src_v[40] = 1'b0;
    step(12'h000, 0, 0, 0);
    src_v[40] = 1'b1;
    wr(12'h120, 32'h0000_0100);                // clear and edge together
    expect_rd(12'h120, 32'h0000_0100, "R3");

    // R5 eligibility gates
    phase = "R5";
    wr(12'h000, 32'h0000_FFF7);
    expect_rd(12'h004, 32'd10, "R5");
    wr(12'h104, 32'hFFFF_FBFF);
    expect_rd(12'h004, 32'h3FF, "R5");
    #1 chk("R5", {31'b0, irq}, 32'd0);
    wr(12'h104, 32'hFFFF_FFFF);
    wr(12'h000, 32'h0000_FFFF);
    expect_rd(12'h004, 32'd40, "R5");

    // R7 take and R8 acknowledge
    phase = "R7";
    step(12'h004, 0, 0, 1);
    expect_rd(12'h004, 32'd10, "R7");
    step(12'h004, 0, 0, 1);
    expect_rd(12'h004, 32'h3FF, "R7");
    phase = "R8";
    wr(12'h004, 32'h0);
    expect_rd(12'h004, 32'd40, "R8");
    wr(12'h004, 32'h0);
    step(12'h004, 0, 0, 1);
    expect_rd(12'h004, 32'd10, "R8");          // level 7 was released too
    wr(12'h004, 32'h0);
    wr(12'h100, 32'h0000_0400);
    wr(12'h120, 32'h0000_0100);

    // R6 software interrupt, R10 masking
    phase = "R6";
    src_v[SWI] = 1'b1;
    step(12'h000, 0, 0, 0);
    expect_rd(12'h120, 32'h0, "R6");
    phase = "R10";
    wr(12'h000, 32'h0000_7FFF);
    wr(12'h008, 32'h1);
    expect_rd(12'h120, 32'h8000_0000, "R6");
    expect_rd(12'h004, 32'h3FF, "R10");
    wr(12'h000, 32'h0000_FFFF);
    expect_rd(12'h004, 32'd63, "R10");
    step(12'h004, 0, 0, 1);
    wr(12'h120, 32'h8000_0000);
    wr(12'h008, 32'h0);
    expect_rd(12'h120, 32'h8000_0000, "R10");
    expect_rd(12'h004, 32'h3FF, "R10");
    wr(12'h004, 32'h0);
    expect_rd(12'h004, 32'd63, "R10");

    // random traffic against the model
    phase = "R4";
    for (int n = 0; n < 3000; n++) begin
      int sel;
      logic [11:0] a;
      logic [31:0] d;
      if ($urandom % 4 == 0) src_v[$urandom % NSRC] ^= 1'b1;
      sel = $urandom % 16;
      d = $urandom;
      case (sel)
        0: a = 12'h000;
        1, 2, 3: a = 12'h004;
        4: a = 12'h008;
        5: a = 12'h00C;
        6, 7: a = 12'h100;
        8, 9: a = 12'h120;
        10: a = 12'h104;
        11: a = 12'h124;
        12: a = 12'h108 + 12'(4 * ($urandom % 4));
        13: a = 12'h128 + 12'(4 * ($urandom % 4));
        14: a = 12'h140;
        default: a = 12'h004;
      endcase
      if (a == 12'h000) d = ($urandom % 2) ? 32'hFFFF : d;
      if (a == 12'h104 || a == 12'h124) d = ($urandom % 2) ? 32'hFFFF_FFFF : d;
      step(a, d, ($urandom % 3) == 0, ($urandom % 2) == 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule